// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the timing skeleton of a raster display: horizontal sync, vertical sync, a data-enable strobe, the pixel and line coordinates inside the visible area, and a single-cycle pulse once the last visible line of a frame has been drawn. It advances one step per pixel clock, which is the block's `clk` input. Pixel fetch, colour packing and clock synthesis are handled elsewhere. A pixel word supplied by the fetch logic is passed through during the visible area, with an optional inversion.

Each direction is split into four phases, always in the same order: visible, front porch, sync, back porch. Every phase length is programmed as its length minus one. A four-bit polarity field selects the active level of hsync, vsync, data-enable and the pixel data separately. A run input starts and stops scanning.

All configuration is copied into a shadow set. While the block is stopped, the copy is taken on every cycle. While it is scanning, the copy is taken only on the last cycle of a frame, so a frame is never drawn with mixed settings.

The control FSM has two states. `ST_IDLE` is stopped, with the counters held at zero and the outputs inactive. `ST_SCAN` is scanning. The transition *launch* (`ST_IDLE`→`ST_SCAN`) is taken when `cfg_run` is 1 at a clock edge. The transition *halt* (`ST_SCAN`→`ST_IDLE`) is taken when `cfg_run` is 0 at a clock edge. Each axis runs a phase sequencer whose states are `PH_ACTIVE`→`PH_FRONT`→`PH_SYNC`→`PH_BACK`→`PH_ACTIVE`. A transition fires when the phase counter equals the programmed value for that phase. The horizontal sequencer steps on every scanning cycle. The vertical sequencer steps once per completed line.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, and from the second clock edge after `cfg_run` goes low, the outputs are inactive: hsync, vsync and data-enable sit at their inactive level, `px_x` = `ln_y` = 0, `vblank_o` = 0, and `pix_o` carries the inactive data level.
- R2: A line lasts (h_act+1)+(h_fp+1)+(h_sync+1)+(h_bp+1) cycles. Its phases run in the order visible, front porch, sync, back porch. Hsync is asserted only in the sync phase.
- R3: A frame lasts (v_act+1)+(v_fp+1)+(v_sync+1)+(v_bp+1) lines, in the same phase order. Vsync is asserted for whole lines in the vertical sync phase.
- R4: Polarity bits are assigned as follows: bit 0 is hsync, bit 1 is vsync, bit 2 is data-enable and bit 3 is pixel data. A 1 makes the signal active-high. A 0 inverts it.
- R5: If `cfg_run` is 1 at a clock edge while stopped, the cycle after that edge is pixel 0 of line 0, with data-enable asserted.
- R6: `vblank_o` is high for exactly one cycle: the final cycle of the last visible line. It is never high while data-enable is active.
- R7: During the visible area, `px_x` and `ln_y` give the pixel index within the line and the line index within the frame. Outside the visible area both read 0, and `px_x` rises by one on each cycle of a visible run.
- R8: Configuration changes made while scanning take effect only from the first cycle of the next frame. While stopped, configuration changes (including polarity) show at the outputs after one edge.
- R9: The raw data is `pix_i` while data-enable is active and 0 otherwise. `pix_o` is this raw value, inverted bitwise when polarity bit 3 is 0.
- R10: If scanning is stopped partway through a frame and started again, the new frame begins at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run | input | 1 | 1 = scan, 0 = stop |
| cfg_h_act | input | HW | Visible pixels per line minus one |
| cfg_h_fp | input | HW | Horizontal front porch minus one |
| cfg_h_sync | input | HW | Hsync width minus one |
| cfg_h_bp | input | HW | Horizontal back porch minus one |
| cfg_v_act | input | VW | Visible lines minus one |
| cfg_v_fp | input | VW | Vertical front porch lines minus one |
| cfg_v_sync | input | VW | Vsync lines minus one |
| cfg_v_bp | input | VW | Vertical back porch lines minus one |
| cfg_pol | input | 4 | Active-high selects: [0] hsync, [1] vsync, [2] DE, [3] data |
| pix_i | input | PIX_W | Pixel word from fetch logic |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_o | output | PIX_W | Pixel word after blanking and polarity |
| vblank_o | output | 1 | One-cycle end-of-visible-frame pulse |
| px_x | output | HW | Pixel index in the visible area |
| ln_y | output | VW | Line index in the visible area |

## Verification
Every output is decoded combinationally from registered state. The launch edge therefore produces pixel 0 of line 0, and after that each edge moves exactly one pixel. A scoreboard takes the expected pixel stream, computed from the programmed lengths, and compares it one item per falling edge, starting with the falling edge that follows the launch edge.

Stop behaviour is due on the second edge after `cfg_run` falls. Idle polarity changes are due one edge after they are driven. The directed checks wait exactly those edges before sampling. For a mid-frame configuration change, the scoreboard expects the old settings up to and including the frame's last cycle and the new settings from the next item on.

// File: rtl/dt_pkg.sv
package dt_pkg;
    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } phase_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } run_e;

    localparam int POL_HS = 0;
    localparam int POL_VS = 1;
    localparam int POL_DE = 2;
    localparam int POL_DATA = 3;
endpackage

// File: rtl/dt_cfg_shadow.sv
module dt_cfg_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/dt_phase_seq.sv
module dt_phase_seq
    import dt_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_fp,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_bp,
    output phase_e       phase,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    phase_e       ph_q, ph_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] cur_len;
    logic         at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_ACTIVE;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        unique case (ph_q)
            PH_ACTIVE: cur_len = len_act;
            PH_FRONT:  cur_len = len_fp;
            PH_SYNC:   cur_len = len_sync;
            PH_BACK:   cur_len = len_bp;
        endcase
        at_end = (cnt_q == cur_len);
        ph_d   = ph_q;
        cnt_d  = cnt_q;
        if (clr) begin
            ph_d  = PH_ACTIVE;
            cnt_d = '0;
        end else if (step) begin
            if (at_end) begin
                cnt_d = '0;
                unique case (ph_q)
                    PH_ACTIVE: ph_d = PH_FRONT;
                    PH_FRONT:  ph_d = PH_SYNC;
                    PH_SYNC:   ph_d = PH_BACK;
                    PH_BACK:   ph_d = PH_ACTIVE;
                endcase
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end
        wrap = step && !clr && (ph_q == PH_BACK) && at_end;
    end

    assign phase = ph_q;
    assign cnt   = cnt_q;
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dt_pkg::*;
#(
    parameter int HW    = 12,
    parameter int VW    = 12,
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_run,
    input  logic [HW-1:0]    cfg_h_act,
    input  logic [HW-1:0]    cfg_h_fp,
    input  logic [HW-1:0]    cfg_h_sync,
    input  logic [HW-1:0]    cfg_h_bp,
    input  logic [VW-1:0]    cfg_v_act,
    input  logic [VW-1:0]    cfg_v_fp,
    input  logic [VW-1:0]    cfg_v_sync,
    input  logic [VW-1:0]    cfg_v_bp,
    input  logic [3:0]       cfg_pol,
    input  logic [PIX_W-1:0] pix_i,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic [PIX_W-1:0] pix_o,
    output logic             vblank_o,
    output logic [HW-1:0]    px_x,
    output logic [VW-1:0]    ln_y
);
    localparam int CFG_W = 4 * HW + 4 * VW + 4;

    run_e st_q, st_d;
    logic scan;

    logic [CFG_W-1:0] sh;
    logic [HW-1:0]    sh_h_act, sh_h_fp, sh_h_sync, sh_h_bp;
    logic [VW-1:0]    sh_v_act, sh_v_fp, sh_v_sync, sh_v_bp;
    logic [3:0]       sh_pol;
    logic             sh_load;

    phase_e        h_ph, v_ph;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          h_wrap, v_wrap;

    logic hs_raw, vs_raw, de_raw;

    // Control FSM: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Control FSM: launch / halt transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (cfg_run)  st_d = ST_SCAN;
            ST_SCAN: if (!cfg_run) st_d = ST_IDLE;
        endcase
    end

    assign scan    = (st_q == ST_SCAN);
    assign sh_load = !scan || v_wrap;

    dt_cfg_shadow #(.W(CFG_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .d     ({cfg_h_act, cfg_h_fp, cfg_h_sync, cfg_h_bp,
                 cfg_v_act, cfg_v_fp, cfg_v_sync, cfg_v_bp, cfg_pol}),
        .q     (sh)
    );

    assign {sh_h_act, sh_h_fp, sh_h_sync, sh_h_bp,
            sh_v_act, sh_v_fp, sh_v_sync, sh_v_bp, sh_pol} = sh;

    dt_phase_seq #(.W(HW)) u_hseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!scan),
        .step     (scan),
        .len_act  (sh_h_act),
        .len_fp   (sh_h_fp),
        .len_sync (sh_h_sync),
        .len_bp   (sh_h_bp),
        .phase    (h_ph),
        .cnt      (h_cnt),
        .wrap     (h_wrap)
    );

    dt_phase_seq #(.W(VW)) u_vseq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!scan),
        .step     (h_wrap),
        .len_act  (sh_v_act),
        .len_fp   (sh_v_fp),
        .len_sync (sh_v_sync),
        .len_bp   (sh_v_bp),
        .phase    (v_ph),
        .cnt      (v_cnt),
        .wrap     (v_wrap)
    );

    // Output decode
    always_comb begin
        hs_raw   = scan && (h_ph == PH_SYNC);
        vs_raw   = scan && (v_ph == PH_SYNC);
        de_raw   = scan && (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);
        hsync_o  = sh_pol[POL_HS] ? hs_raw : !hs_raw;
        vsync_o  = sh_pol[POL_VS] ? vs_raw : !vs_raw;
        de_o     = sh_pol[POL_DE] ? de_raw : !de_raw;
        pix_o    = de_raw ? pix_i : '0;
        if (!sh_pol[POL_DATA]) pix_o = ~pix_o;
        vblank_o = h_wrap && (v_ph == PH_ACTIVE) && (v_cnt == sh_v_act);
        px_x     = de_raw ? h_cnt : '0;
        ln_y     = de_raw ? v_cnt : '0;
    end
endmodule

// File: rtl/dt_checker.sv
module dt_checker #(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_run,
    input logic          act,
    input logic          hs_act,
    input logic          vblank,
    input logic [HW-1:0] px_x,
    input logic [VW-1:0] ln_y
);
    localparam logic [HW-1:0] XONE = HW'(1);

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_run |=> (px_x == '0 && ln_y == '0 && !vblank)); // R1

    AST_SYNC_OUTSIDE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_act && act)); // R2

    AST_VBLANK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> !vblank); // R6

    AST_VBLANK_NOT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |-> !act); // R6

    AST_X_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act)) |-> (px_x == $past(px_x) + XONE)); // R7

    AST_Y_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act)) |-> (ln_y == $past(ln_y))); // R7
endmodule

bind disp_timing_gen dt_checker #(.HW(HW), .VW(VW)) u_dt_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_run (cfg_run),
    .act     (de_raw),
    .hs_act  (hs_raw),
    .vblank  (vblank_o),
    .px_x    (px_x),
    .ln_y    (ln_y)
);

// File: tb/test_disp_timing_gen.sv
`timescale 1ns/1ps
module test_disp_timing_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_run = 1'b0;
    logic [11:0] cfg_h_act = '0, cfg_h_fp = '0, cfg_h_sync = '0, cfg_h_bp = '0;
    logic [11:0] cfg_v_act = '0, cfg_v_fp = '0, cfg_v_sync = '0, cfg_v_bp = '0;
    logic [3:0]  cfg_pol = '0;
    logic [23:0] pix_i = 24'h5A3C96;
    logic        hsync_o, vsync_o, de_o, vblank_o;
    logic [23:0] pix_o;
    logic [11:0] px_x, ln_y;

    always #2 clk = ~clk;

    disp_timing_gen i_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run),
        .cfg_h_act(cfg_h_act), .cfg_h_fp(cfg_h_fp), .cfg_h_sync(cfg_h_sync), .cfg_h_bp(cfg_h_bp),
        .cfg_v_act(cfg_v_act), .cfg_v_fp(cfg_v_fp), .cfg_v_sync(cfg_v_sync), .cfg_v_bp(cfg_v_bp),
        .cfg_pol(cfg_pol), .pix_i(pix_i),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pix_o(pix_o),
        .vblank_o(vblank_o), .px_x(px_x), .ln_y(ln_y)
    );

    typedef struct packed {
        logic        hs, vs, de, vb;
        logic [11:0] x, y;
        logic [23:0] pix;
    } item_t;

    item_t exp_q[$];
    int    hl[4];
    int    vl[4];
    logic [3:0] pol;
    int    n_checks = 0;
    int    n_fail = 0;
    bit    mon_en = 0;
    bit    done = 0;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic apply_cfg();
        cfg_h_act = 12'(hl[0] - 1); cfg_h_fp = 12'(hl[1] - 1);
        cfg_h_sync = 12'(hl[2] - 1); cfg_h_bp = 12'(hl[3] - 1);
        cfg_v_act = 12'(vl[0] - 1); cfg_v_fp = 12'(vl[1] - 1);
        cfg_v_sync = 12'(vl[2] - 1); cfg_v_bp = 12'(vl[3] - 1);
        cfg_pol = pol;
    endtask

    function automatic int phase_of(int pos, int a, int b, int c);
        if (pos < a) return 0;
        if (pos < a + b) return 1;
        if (pos < a + b + c) return 2;
        return 3;
    endfunction

    // Driver: expected stream for one whole frame under current hl/vl/pol (R2 R3 R4 R6 R7 R9)
    task automatic push_frame();
        int htot = hl[0] + hl[1] + hl[2] + hl[3];
        int vtot = vl[0] + vl[1] + vl[2] + vl[3];
        for (int l = 0; l < vtot; l++) begin
            for (int p = 0; p < htot; p++) begin
                item_t it;
                int hp = phase_of(p, hl[0], hl[1], hl[2]);
                int vp = phase_of(l, vl[0], vl[1], vl[2]);
                logic de = (hp == 0) && (vp == 0);
                it.hs  = pol[0] ? (hp == 2) : !(hp == 2);
                it.vs  = pol[1] ? (vp == 2) : !(vp == 2);
                it.de  = pol[2] ? de : !de;
                it.vb  = (l == vl[0] - 1) && (p == htot - 1);
                it.x   = de ? 12'(p) : 12'd0;
                it.y   = de ? 12'(l) : 12'd0;
                it.pix = de ? pix_i : 24'd0;
                if (!pol[3]) it.pix = ~it.pix;
                exp_q.push_back(it);
            end
        end
    endtask

    // Monitor: pops one expected item per falling edge
    always @(negedge clk) begin
        if (mon_en) begin
            if (exp_q.size() == 0) mon_en = 0;
            else begin
                item_t e;
                e = exp_q.pop_front();
                check("R2", "hsync", 32'(hsync_o), 32'(e.hs));
                check("R3", "vsync", 32'(vsync_o), 32'(e.vs));
                check("R5", "de", 32'(de_o), 32'(e.de));
                check("R6", "vblank", 32'(vblank_o), 32'(e.vb));
                check("R7", "x", 32'(px_x), 32'(e.x));
                check("R7", "y", 32'(ln_y), 32'(e.y));
                check("R9", "pix", 32'(pix_o), 32'(e.pix));
            end
        end
    end

    task automatic start_and_drain();
        @(negedge clk); #1; cfg_run = 1'b1; mon_en = 1;
        wait (exp_q.size() == 0);
        @(negedge clk); @(negedge clk); #1; cfg_run = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic idle_check(string req, logic [3:0] p);
        check(req, "idle hsync", 32'(hsync_o), 32'(!p[0]));
        check(req, "idle vsync", 32'(vsync_o), 32'(!p[1]));
        check(req, "idle de", 32'(de_o), 32'(!p[2]));
        check(req, "idle pix", 32'(pix_o), p[3] ? 32'd0 : 32'h00FFFFFF);
        check(req, "idle x", 32'(px_x), 32'd0);
        check(req, "idle y", 32'(ln_y), 32'd0);
        check(req, "idle vblank", 32'(vblank_o), 32'd0);
    endtask

    initial begin
        hl = '{4, 2, 3, 2}; vl = '{3, 1, 2, 1}; pol = 4'b0101;
        apply_cfg();
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        idle_check("R1", pol);

        // R4/R8: idle polarity change shows after one edge
        @(negedge clk); #1; pol = 4'b1010; apply_cfg();
        @(negedge clk);
        idle_check("R8", pol);

        // Full frame, all active-high (R2 R3 R5 R6 R7 R9)
        pol = 4'b1111; apply_cfg();
        push_frame();
        start_and_drain();
        idle_check("R1", pol);

        // Mid-frame config change only applies at next frame (R8, R4)
        pol = 4'b0000; apply_cfg();
        push_frame();
        hl = '{3, 1, 1, 1}; vl = '{2, 1, 1, 2}; pol = 4'b1010;
        push_frame();
        hl = '{4, 2, 3, 2}; vl = '{3, 1, 2, 1}; pol = 4'b0000;
        @(negedge clk); #1; cfg_run = 1'b1; mon_en = 1;
        repeat (20) @(negedge clk);
        #1; hl = '{3, 1, 1, 1}; vl = '{2, 1, 1, 2}; pol = 4'b1010; apply_cfg();
        wait (exp_q.size() == 0);
        @(negedge clk); @(negedge clk); #1; cfg_run = 1'b0;
        @(negedge clk); @(negedge clk);
        idle_check("R1", pol);

        // Stop mid-frame, restart from origin (R10, R5)
        @(negedge clk); #1; cfg_run = 1'b1;
        repeat (13) @(negedge clk);
        #1; cfg_run = 1'b0;
        @(negedge clk); @(negedge clk);
        idle_check("R1", pol);
        push_frame();
        @(negedge clk); #1; cfg_run = 1'b1; mon_en = 1;
        @(negedge clk); #1;
        check("R10", "restart x", 32'(px_x), 32'd0);
        check("R10", "restart y", 32'(ln_y), 32'd0);
        check("R5", "restart de", 32'(de_o), 32'(pol[2]));
        wait (exp_q.size() == 0);
        @(negedge clk); @(negedge clk); #1; cfg_run = 1'b0;
        @(negedge clk);
        done = 1;
    end

    int wd = 0;
    initial begin
        while (!done && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", wd);
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule